// File: doc/BRIEF.md
# Test Line Observation Multiplexer

This block picks one internal trit line of the horizontal routing channels and puts it on a single trit-wide test output. The choice is made by a 7-bit binary test address. Each channel carries fifteen lines, but one of them is the channel's IO pin. A pin can already be watched at the package, so pins never reach this block and take no address. Two codes are reserved. The lowest address shows the serial data output of the configuration SPI slave. The highest address shows the reference level.

The block is purely combinational and has no clock. A tester sets the address and reads the output after the logic settles. The number of channels is a parameter. Any address above the last internal line, other than the top code, drives the neutral trit.

Top module: `tline_probe_mux`

## Requirements
- R1: Trits are two bits wide: O = 2'b00, P = 2'b01, N = 2'b10. At address 0 the output shows the SPI serial data bit: 0 gives N (2'b10) and 1 gives P (2'b01).
- R2: Address 2**ADDR_W-1 (127 by default) drives O (2'b00), whatever the lines and the serial bit hold.
- R3: Address a in 1..NUM_CHAN*14 selects line l = (a-1) mod 14 of channel c = (a-1)/14. That line sits at bits [2*(c*14+l)+1 : 2*(c*14+l)] of lines_i.
- R4: The IO pin line of each channel has no place on lines_i and uses no address. Consecutive channels are therefore contiguous in the address space: address 14*c+1 selects line 0 of channel c.
- R5: Addresses above NUM_CHAN*14 and below 2**ADDR_W-1 drive O (2'b00).
- R6: The output depends only on the present inputs. It follows an address change without any clock edge.
- R7: The serial data bit has no effect on the output at any nonzero address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_addr_i | input | ADDR_W | Binary test address |
| spi_sdo_i | input | 1 | Serial data output of the configuration SPI slave |
| lines_i | input | NUM_CHAN*(LINES_PER_CHAN-1)*2 | Internal channel lines, two bits per trit |
| test_o | output | 2 | Selected trit |

## Verification
Every result is due in the same evaluation as its stimulus, because no register lies between any input and test_o. The bench changes inputs just after a rising edge of its own clock and compares at the following falling edge, half a period later. A single check instead changes the address between edges and compares 2 ns later, with no edge in between, to show that the path is combinational. The full address space is swept on a nine-channel instance and on a four-channel instance, under five line patterns in which each line carries a different base-3 digit of its own index, so no two lines agree on every pass.

// File: rtl/tprobe_pkg.sv
package tprobe_pkg;
  typedef logic [1:0] trit_t;
  localparam trit_t TRIT_O = 2'b00;
  localparam trit_t TRIT_P = 2'b01;
  localparam trit_t TRIT_N = 2'b10;
endpackage

// File: rtl/tprobe_addr_dec.sv
module tprobe_addr_dec #(
  parameter int NUM_CHAN     = 9,
  parameter int INT_PER_CHAN = 14,
  parameter int ADDR_W       = 7,
  parameter int LIDX_W       = 4
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                sel_sdo_o,
  output logic                sel_ref_o,
  output logic [NUM_CHAN-1:0] chan_oh_o,
  output logic [LIDX_W-1:0]   line_idx_o
);
  localparam int unsigned REF_CODE = (1 << ADDR_W) - 1;

  int unsigned addr_int;

  assign addr_int  = 32'(addr_i);
  assign sel_sdo_o = (addr_int == 0);
  assign sel_ref_o = (addr_int == REF_CODE);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan_hit
    localparam int unsigned BASE = 1 + c * INT_PER_CHAN;
    assign chan_oh_o[c] = !sel_ref_o && (addr_int >= BASE) &&
                          (addr_int < BASE + INT_PER_CHAN);
  end

  always_comb begin
    line_idx_o = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (chan_oh_o[c]) line_idx_o = LIDX_W'(addr_int - 32'(1 + c * INT_PER_CHAN));
    end
  end

  always_comb begin
    // R3
    chan_onehot_chk: assert ($onehot0(chan_oh_o));
    // R3
    if (chan_oh_o != '0) begin
      line_range_chk: assert (32'(line_idx_o) < 32'(INT_PER_CHAN));
    end
    // R1
    if (sel_sdo_o) begin
      sdo_no_chan_chk: assert (chan_oh_o == '0);
    end
  end
endmodule

// File: rtl/tprobe_line_sel.sv
module tprobe_line_sel
  import tprobe_pkg::*;
#(
  parameter int NUM_CHAN     = 9,
  parameter int INT_PER_CHAN = 14,
  parameter int LIDX_W       = 4
) (
  input  logic [NUM_CHAN*INT_PER_CHAN*2-1:0] lines_i,
  input  logic [NUM_CHAN-1:0]                chan_oh_i,
  input  logic [LIDX_W-1:0]                  line_idx_i,
  output trit_t                              line_trit_o,
  output logic                               line_hit_o
);
  trit_t ch_val [NUM_CHAN];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan_mux
    always_comb begin
      ch_val[c] = TRIT_O;
      for (int l = 0; l < INT_PER_CHAN; l++) begin
        if (line_idx_i == LIDX_W'(l)) ch_val[c] = lines_i[2*(c*INT_PER_CHAN+l) +: 2];
      end
    end
  end

  always_comb begin
    line_trit_o = TRIT_O;
    for (int c = 0; c < NUM_CHAN; c++) begin
      line_trit_o = line_trit_o | (ch_val[c] & {2{chan_oh_i[c]}});
    end
  end

  assign line_hit_o = |chan_oh_i;

  always_comb begin
    // R5
    if (!line_hit_o) begin
      idle_neutral_chk: assert (line_trit_o == TRIT_O);
    end
  end
endmodule

// File: rtl/tprobe_out_mux.sv
module tprobe_out_mux
  import tprobe_pkg::*;
(
  input  logic  sel_sdo_i,
  input  logic  sel_ref_i,
  input  logic  line_hit_i,
  input  logic  sdo_i,
  input  trit_t line_trit_i,
  output trit_t trit_o
);
  always_comb begin
    if (sel_sdo_i)       trit_o = sdo_i ? TRIT_P : TRIT_N;
    else if (sel_ref_i)  trit_o = TRIT_O;
    else if (line_hit_i) trit_o = line_trit_i;
    else                 trit_o = TRIT_O;
  end
endmodule

// File: rtl/tline_probe_mux.sv
module tline_probe_mux
  import tprobe_pkg::*;
#(
  parameter int NUM_CHAN       = 9,
  parameter int LINES_PER_CHAN = 15,
  parameter int ADDR_W         = 7
) (
  input  logic [ADDR_W-1:0]                         test_addr_i,
  input  logic                                      spi_sdo_i,
  input  logic [NUM_CHAN*(LINES_PER_CHAN-1)*2-1:0]  lines_i,
  output logic [1:0]                                test_o
);
  localparam int INT_PER_CHAN = LINES_PER_CHAN - 1;
  localparam int LIDX_W       = (INT_PER_CHAN > 1) ? $clog2(INT_PER_CHAN) : 1;

  logic                sel_sdo;
  logic                sel_ref;
  logic                line_hit;
  logic [NUM_CHAN-1:0] chan_oh;
  logic [LIDX_W-1:0]   line_idx;
  trit_t               line_trit;
  trit_t               out_trit;

  tprobe_addr_dec #(
    .NUM_CHAN(NUM_CHAN), .INT_PER_CHAN(INT_PER_CHAN),
    .ADDR_W(ADDR_W), .LIDX_W(LIDX_W)
  ) addr_dec_i (
    .addr_i(test_addr_i), .sel_sdo_o(sel_sdo), .sel_ref_o(sel_ref),
    .chan_oh_o(chan_oh), .line_idx_o(line_idx)
  );

  tprobe_line_sel #(
    .NUM_CHAN(NUM_CHAN), .INT_PER_CHAN(INT_PER_CHAN), .LIDX_W(LIDX_W)
  ) line_sel_i (
    .lines_i(lines_i), .chan_oh_i(chan_oh), .line_idx_i(line_idx),
    .line_trit_o(line_trit), .line_hit_o(line_hit)
  );

  tprobe_out_mux out_mux_i (
    .sel_sdo_i(sel_sdo), .sel_ref_i(sel_ref), .line_hit_i(line_hit),
    .sdo_i(spi_sdo_i), .line_trit_i(line_trit), .trit_o(out_trit)
  );

  assign test_o = out_trit;

  always_comb begin
    // R1
    if (test_addr_i == '0) begin
      sdo_code_chk: assert (test_o == (spi_sdo_i ? TRIT_P : TRIT_N));
    end
    // R2
    if (test_addr_i == '1) begin
      ref_code_chk: assert (test_o == TRIT_O);
    end
    // R1
    valid_code_chk: assert ((test_o != 2'b11) || (line_hit && line_trit == 2'b11));
  end
endmodule

// File: tb/tline_probe_mux_tb.sv
module tline_probe_mux_tb_top;
  localparam int BIG_CH   = 9;
  localparam int SMALL_CH = 4;
  localparam int PERLINE  = 14;

  logic                        clk = 1'b0;
  logic [6:0]                  addr;
  logic                        sdo;
  logic [BIG_CH*PERLINE*2-1:0]   lines_big;
  logic [SMALL_CH*PERLINE*2-1:0] lines_small;
  logic [1:0]                  out_big;
  logic [1:0]                  out_small;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tline_probe_mux #(.NUM_CHAN(BIG_CH)) dut_i (
    .test_addr_i(addr), .spi_sdo_i(sdo), .lines_i(lines_big), .test_o(out_big)
  );

  tline_probe_mux #(.NUM_CHAN(SMALL_CH)) dut_small_i (
    .test_addr_i(addr), .spi_sdo_i(sdo), .lines_i(lines_small), .test_o(out_small)
  );

  function automatic logic [1:0] digit_trit(int g, int k);
    int p = 1;
    int d;
    for (int i = 0; i < k; i++) p = p * 3;
    d = (g / p) % 3;
    return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] model(int a, bit s, int nch, int k);
    if (a == 0) return s ? 2'b01 : 2'b10;
    if (a == 127) return 2'b00;
    if (a - 1 < nch * PERLINE) return digit_trit(a - 1, k);
    return 2'b00;
  endfunction

  function automatic string tag_of(int a, int nch);
    if (a == 0) return "R1";
    if (a == 127) return "R2";
    if (a - 1 < nch * PERLINE) return (((a - 1) % PERLINE) == 0 && a > 1) ? "R4" : "R3";
    return "R5";
  endfunction

  task automatic check(string tag, logic [1:0] got, logic [1:0] exp, int a);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%b expected=%b", tag, a, got, exp);
    end
  endtask

  task automatic load_pattern(int k);
    for (int g = 0; g < BIG_CH * PERLINE; g++) lines_big[2*g +: 2] = digit_trit(g, k);
    for (int g = 0; g < SMALL_CH * PERLINE; g++) lines_small[2*g +: 2] = digit_trit(g, k);
  endtask

  initial begin
    addr = '0;
    sdo = 1'b0;
    lines_big = '0;
    lines_small = '0;
    @(negedge clk);
    check("R1", out_big, 2'b10, 0);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      load_pattern(k);
      for (int a = 0; a < 128; a++) begin
        for (int s = 0; s < 2; s++) begin
          @(posedge clk);
          addr = 7'(a);
          sdo = s[0] ^ k[0];
          @(negedge clk);
          if (s == 1 && a != 0) begin
            check("R7", out_big,   model(a, sdo, BIG_CH, k),   a);
            check("R7", out_small, model(a, sdo, SMALL_CH, k), a);
          end else begin
            check(tag_of(a, BIG_CH),   out_big,   model(a, sdo, BIG_CH, k),   a);
            check(tag_of(a, SMALL_CH), out_small, model(a, sdo, SMALL_CH, k), a);
          end
        end
      end
    end
    // R6: address change between edges, sampled with no edge in between
    @(posedge clk);
    load_pattern(0);
    addr = 7'd5;
    #3;
    addr = 7'd20;
    #2;
    check("R6", out_big, model(20, sdo, BIG_CH, 0), 20);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule